// File: doc/BRIEF.md
# DRAM Command and Bank-State Tracker

This block sits beside the command pins of a four-bank DDR mobile DRAM interface and samples them on every rising clock edge. It decodes chip select, row strobe, column strobe and write enable into a command. For each bank it keeps a registered idle or active state and the open row. It records the most recent mode-register load. When clock enable drops, it sorts the low period into precharge power-down, active power-down or self refresh.

The block also raises sticky error flags for protocol misuse: an access to a closed bank, a row activation on a bank that is already open, a refresh with a row open, and clock enable dropping while a burst runs. Auto-precharge is modelled with a single burst counter. The block only observes and never drives the bus, so it can watch a controller in a larger design.

Top module: `dram_cmd_tracker`

## Requirements
- R1: With `cs_n` high, the cycle is a no-operation: no bank state, open row, mode-register output or error flag changes because of the sampled RAS/CAS/WE/BA/address values.
- R2: With `cs_n` low and {ras_n,cas_n,we_n}=011 (activate) to an idle bank, that bank reads active and its open row equals `addr` after the edge. The open row of an idle bank reads zero. Bank i's row sits at `open_rows[i*13 +: 13]`.
- R3: A precharge ({ras_n,cas_n,we_n}=010) with `addr[10]` low closes only the bank on `ba`. With `addr[10]` high it closes every bank.
- R4: A mode-register load (000) copies `ba` into `mr_sel` and `addr` into `mr_op`, and sets `mr_valid`.
- R5: A read (101) or write (100) to an idle bank sets `err_flags[0]`. An activate to an active bank sets `err_flags[1]` and leaves that bank's row unchanged. Error flags clear only on reset.
- R6: A refresh (001) while any bank is active sets `err_flags[2]`.
- R7: A read or write to an active bank with `addr[10]` high closes that bank on the fourth rising edge after the command edge. The close comes earlier if a burst terminate (110) ends the burst, or if a new access to another bank interrupts it. A precharge that covers the bank cancels the pending close. The burst lasts four cycles.
- R8: On the edge where `cke` is first sampled low, `pwr_mode` becomes 2 (active power-down) if any bank is active. Otherwise it becomes 3 (self refresh) if the sampled command is a refresh, and 1 (precharge power-down) if not. `pwr_mode` 0 means running.
- R9: `cke` sampled low while a burst is running sets `err_flags[3]` and abandons the burst, including any pending auto-precharge.
- R10: Commands are ignored on the power-down entry edge and throughout power-down. The first edge with `cke` high returns `pwr_mode` to 0 with all banks idle and all rows zero.
- R11: Synchronous reset clears all banks, rows, `pwr_mode`, mode-register outputs and error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address / mode-register target |
| addr | input | 13 | Row, column, precharge-all bit (10) or op-code |
| bank_active | output | 4 | One bit per bank, 1 = row open |
| open_rows | output | 52 | Open row per bank, 13 bits each |
| pwr_mode | output | 2 | 0 run, 1 precharge power-down, 2 active power-down, 3 self refresh |
| mr_sel | output | 2 | Target of the last mode-register load |
| mr_op | output | 13 | Op-code of the last mode-register load |
| mr_valid | output | 1 | A mode-register load has been seen |
| err_flags | output | 4 | Sticky: 0 access to idle, 1 reopen, 2 refresh while open, 3 cke low in burst |

## Verification
Several rules are checked on every cycle by the assertions: a deselected cycle leaves the bank states alone, a precharge-all empties every bank, and wake-up clears all banks. They also check that error flags never fall, that active power-down always holds an open row while the other low-power modes hold none, and that the burst counter stays in range. Other behaviour depends on a history of commands, and only the bench scenarios can show it. This covers the exact edge on which auto-precharge closes a bank, a burst cut short by terminate or by a new access, an abandoned burst when clock enable drops, and the choice between self refresh and precharge power-down. The bench compares these against its own model over random command streams with periodic resets.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_PPD  = 2'd1,
    PWR_APD  = 2'd2,
    PWR_SREF = 2'd3
  } pwr_e;

  // A deselected cycle is a no-operation; otherwise the three strobes are the code.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    if (cs_n) return CMD_NOP;
    return cmd_e'({ras_n, cas_n, we_n});
  endfunction

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

  // Low-power mode chosen on the edge where clock enable is first seen low.
  function automatic pwr_e classify_entry(input logic any_open, input logic is_ref);
    if (any_open) return PWR_APD;
    if (is_ref)   return PWR_SREF;
    return PWR_PPD;
  endfunction

endpackage

// File: rtl/dct_cmd_decode.sv
module dct_cmd_decode
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  output cmd_e                 cmd,
  output logic                 is_acc,
  output logic [NUM_BANKS-1:0] bank_sel
);

  always_comb begin
    cmd    = decode_cmd(cs_n, ras_n, cas_n, we_n);
    is_acc = is_access(cmd);
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign bank_sel[i] = (ba == BA_W'(i));
  end

endmodule

// File: rtl/dct_bank_slot.sv
module dct_bank_slot #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_evt,
  input  logic             close_evt,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] row
);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      row    <= '0;
    end else if (close_evt) begin
      active <= 1'b0;
      row    <= '0;
    end else if (open_evt) begin
      active <= 1'b1;
      row    <= row_in;
    end
  end

  assert_open_row_R2: assert property (@(posedge clk) disable iff (rst)
    (open_evt && !close_evt) |=> (active && row == $past(row_in)));

  assert_idle_row_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !active |-> (row == '0));

endmodule

// File: rtl/dct_burst_ctrl.sv
module dct_burst_ctrl #(
  parameter int BURST_LEN = 4,
  parameter int BA_W      = 2,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abort,
  input  logic            start,
  input  logic            start_ap,
  input  logic [BA_W-1:0] start_bank,
  input  logic            bst,
  input  logic            pre_hit,
  output logic            busy,
  output logic            ap_fire,
  output logic [BA_W-1:0] ap_bank
);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic             pend, pend_n;
  logic [BA_W-1:0]  bank_n;

  always_comb begin
    cnt_n   = cnt;
    pend_n  = pend;
    bank_n  = ap_bank;
    ap_fire = 1'b0;
    if (abort) begin
      cnt_n  = '0;
      pend_n = 1'b0;
    end else if (start) begin
      ap_fire = pend && (ap_bank != start_bank);
      cnt_n   = CNT_W'(BURST_LEN);
      pend_n  = start_ap;
      bank_n  = start_bank;
    end else if (bst) begin
      ap_fire = pend;
      cnt_n   = '0;
      pend_n  = 1'b0;
    end else begin
      if (cnt == CNT_W'(1)) begin
        ap_fire = pend && !pre_hit;
        cnt_n   = '0;
        pend_n  = 1'b0;
      end else if (cnt != '0) begin
        cnt_n = cnt - CNT_W'(1);
      end
      if (pre_hit) pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pend    <= 1'b0;
      ap_bank <= '0;
    end else begin
      cnt     <= cnt_n;
      pend    <= pend_n;
      ap_bank <= bank_n;
    end
  end

  assign busy = (cnt != '0);

  always_comb begin
    assert_cnt_range_R7: assert (rst || cnt <= CNT_W'(BURST_LEN));
  end

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && !pend));

endmodule

// File: rtl/dct_power_fsm.sv
module dct_power_fsm
  import dct_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic any_open,
  input  logic is_ref,
  output pwr_e mode,
  output logic exec,
  output logic pd_entry,
  output logic pd_exit
);

  always_comb begin
    exec     = (mode == PWR_RUN) && cke;
    pd_entry = (mode == PWR_RUN) && !cke;
    pd_exit  = (mode != PWR_RUN) && cke;
  end

  always_ff @(posedge clk) begin
    if (rst)           mode <= PWR_RUN;
    else if (pd_entry) mode <= classify_entry(any_open, is_ref);
    else if (pd_exit)  mode <= PWR_RUN;
  end

  assert_run_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == PWR_RUN && cke) |=> (mode == PWR_RUN));

  assert_low_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mode != PWR_RUN && !cke) |=> $stable(mode));

endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic [1:0]                 pwr_mode,
  output logic [BA_W-1:0]            mr_sel,
  output logic [ROW_W-1:0]           mr_op,
  output logic                       mr_valid,
  output logic [3:0]                 err_flags
);

  cmd_e                 cmd;
  logic                 is_acc;
  logic [NUM_BANKS-1:0] bank_sel;
  pwr_e                 mode;
  logic                 exec, pd_entry, pd_exit;
  logic                 burst_busy, ap_fire;
  logic [BA_W-1:0]      ap_bank;

  // Named internal events
  logic any_open, tgt_open, ap_flag;
  logic ev_act, ev_pre, ev_acc, ev_ref, ev_mrs, ev_bst;
  logic start, pre_hit;
  logic err_rw_idle, err_reopen, err_ref_open, err_cke_burst;
  logic [NUM_BANKS-1:0] open_evt, close_evt;

  dct_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .cmd(cmd), .is_acc(is_acc), .bank_sel(bank_sel)
  );

  always_comb begin
    any_open = |bank_active;
    tgt_open = |(bank_active & bank_sel);
    ap_flag  = addr[AP_BIT];
    ev_act   = exec && (cmd == CMD_ACT);
    ev_pre   = exec && (cmd == CMD_PRE);
    ev_acc   = exec && is_acc;
    ev_ref   = exec && (cmd == CMD_REF);
    ev_mrs   = exec && (cmd == CMD_MRS);
    ev_bst   = exec && (cmd == CMD_BST);
    start    = ev_acc && tgt_open;
    pre_hit  = ev_pre && (ap_flag || (ap_bank == ba));
    err_rw_idle   = ev_acc && !tgt_open;
    err_reopen    = ev_act && tgt_open;
    err_ref_open  = ev_ref && any_open;
    err_cke_burst = pd_entry && burst_busy;
  end

  dct_power_fsm u_pwr (
    .clk(clk), .rst(rst), .cke(cke), .any_open(any_open),
    .is_ref(cmd == CMD_REF), .mode(mode), .exec(exec),
    .pd_entry(pd_entry), .pd_exit(pd_exit)
  );

  dct_burst_ctrl #(.BURST_LEN(BURST_LEN), .BA_W(BA_W)) u_burst (
    .clk(clk), .rst(rst), .abort(pd_entry), .start(start),
    .start_ap(ap_flag), .start_bank(ba), .bst(ev_bst), .pre_hit(pre_hit),
    .busy(burst_busy), .ap_fire(ap_fire), .ap_bank(ap_bank)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign open_evt[i]  = ev_act && bank_sel[i] && !bank_active[i];
    assign close_evt[i] = pd_exit
                        || (ev_pre && (ap_flag || bank_sel[i]))
                        || (ap_fire && (ap_bank == BA_W'(i)));
    dct_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk(clk), .rst(rst), .open_evt(open_evt[i]), .close_evt(close_evt[i]),
      .row_in(addr), .active(bank_active[i]), .row(open_rows[i*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mr_sel    <= '0;
      mr_op     <= '0;
      mr_valid  <= 1'b0;
      err_flags <= '0;
    end else begin
      if (ev_mrs) begin
        mr_sel   <= ba;
        mr_op    <= addr;
        mr_valid <= 1'b1;
      end
      err_flags <= err_flags | {err_cke_burst, err_ref_open, err_reopen, err_rw_idle};
    end
  end

  assign pwr_mode = mode;

  assert_cs_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (cs_n && mode == PWR_RUN && cke && !ap_fire) |=> $stable(bank_active));

  assert_pre_all_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_pre && ap_flag) |=> (bank_active == '0));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_apd_open_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == PWR_APD) |-> any_open);

  assert_idle_pd_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == PWR_PPD || mode == PWR_SREF) |-> (bank_active == '0));

  assert_cke_err_R9: assert property (@(posedge clk) disable iff (rst)
    (pd_entry && burst_busy) |=> err_flags[3]);

  assert_wake_R10: assert property (@(posedge clk) disable iff (rst)
    (mode != PWR_RUN && cke) |=> (mode == PWR_RUN && bank_active == '0));

endmodule

// File: tb/dram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module dram_cmd_tracker_tb;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011;
  localparam logic [2:0] C_WR  = 3'b100, C_RD  = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  bank_active;
  logic [51:0] open_rows;
  logic [1:0]  pwr_mode;
  logic [1:0]  mr_sel;
  logic [12:0] mr_op;
  logic        mr_valid;
  logic [3:0]  err_flags;

  int n_tests = 0;
  int n_fail  = 0;

  // Bench model state
  logic [3:0]  m_act;
  logic [12:0] m_row [4];
  int          m_pwr, m_cnt, m_apb;
  logic        m_pend;
  logic [3:0]  m_err;
  logic [1:0]  m_mrsel;
  logic [12:0] m_mrop;
  logic        m_mrv;

  always #2.5 clk = ~clk;

  dram_cmd_tracker u_dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bank_active(bank_active),
    .open_rows(open_rows), .pwr_mode(pwr_mode), .mr_sel(mr_sel), .mr_op(mr_op),
    .mr_valid(mr_valid), .err_flags(err_flags)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic close_bank(input int b);
    m_act[b] = 1'b0;
    m_row[b] = '0;
  endtask

  task automatic model_step();
    logic [2:0] c;
    int b;
    int fb;
    logic fire, started;
    c = cs_n ? C_NOP : {ras_n, cas_n, we_n};
    b = int'(ba);
    fb = m_apb;
    fire = 1'b0;
    started = 1'b0;
    if (rst) begin
      m_act = '0; for (int i = 0; i < 4; i++) m_row[i] = '0;
      m_pwr = 0; m_cnt = 0; m_apb = 0; m_pend = 0; m_err = '0;
      m_mrsel = '0; m_mrop = '0; m_mrv = 0;
    end else if (m_pwr == 0 && !cke) begin
      if (m_cnt != 0) m_err[3] = 1'b1;
      m_cnt = 0; m_pend = 0;
      m_pwr = (m_act != 0) ? 2 : ((c == C_REF) ? 3 : 1);
    end else if (m_pwr != 0) begin
      if (cke) begin
        m_pwr = 0;
        for (int i = 0; i < 4; i++) close_bank(i);
      end
    end else begin
      case (c)
        C_ACT: if (m_act[b]) m_err[1] = 1'b1;
               else begin m_act[b] = 1'b1; m_row[b] = addr; end
        C_RD, C_WR: if (!m_act[b]) m_err[0] = 1'b1;
               else begin
                 if (m_pend && m_apb != b) fire = 1'b1;
                 m_cnt = BL; m_pend = addr[10]; m_apb = b; started = 1'b1;
               end
        C_PRE: begin
                 if (addr[10]) for (int i = 0; i < 4; i++) close_bank(i);
                 else close_bank(b);
                 if (addr[10] || m_apb == b) m_pend = 1'b0;
               end
        C_REF: if (m_act != 0) m_err[2] = 1'b1;
        C_MRS: begin m_mrsel = ba; m_mrop = addr; m_mrv = 1'b1; end
        C_BST: begin fire = m_pend; m_cnt = 0; m_pend = 1'b0; started = 1'b1; end
        default: ;
      endcase
      if (!started) begin
        if (m_cnt == 1) begin fire = m_pend; m_cnt = 0; m_pend = 1'b0; end
        else if (m_cnt != 0) m_cnt--;
      end
      if (fire) close_bank(fb);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3/R7 bank_active", 64'(bank_active), 64'(m_act));
    for (int i = 0; i < 4; i++) chk("R2 open_row", 64'(open_rows[i*13 +: 13]), 64'(m_row[i]));
    chk("R8/R10 pwr_mode", 64'(pwr_mode), 64'(m_pwr));
    chk("R4 mode register", 64'({mr_valid, mr_sel, mr_op}), 64'({m_mrv, m_mrsel, m_mrop}));
    chk("R5/R6/R9 err_flags", 64'(err_flags), 64'(m_err));
  endtask

  task automatic cyc(input logic k, input logic c_n, input logic [2:0] cm,
                     input logic [1:0] b, input logic [12:0] a);
    cke = k; cs_n = c_n; {ras_n, cas_n, we_n} = cm; ba = b; addr = a;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    rst = 1'b1;
    cyc(1, 1, C_NOP, 0, 0);
    cyc(1, 1, C_NOP, 0, 0);
    rst = 1'b0;
    // R11 reset state
    chk("R11 reset", 64'({bank_active, pwr_mode, mr_valid, err_flags}), 64'(0));
    cyc(1, 0, C_ACT, 2, 13'h1ABC);
    chk("R2 activate", 64'(bank_active), 64'(4'b0100));
    chk("R2 row", 64'(open_rows[26 +: 13]), 64'(13'h1ABC));
    cyc(1, 1, C_ACT, 1, 13'h0055);
    chk("R1 deselect", 64'(bank_active), 64'(4'b0100));
    cyc(1, 0, C_ACT, 0, 13'h0005);
    cyc(1, 0, C_PRE, 2, 13'h0000);
    chk("R3 single precharge", 64'(bank_active), 64'(4'b0001));
    cyc(1, 0, C_ACT, 3, 13'h0077);
    cyc(1, 0, C_PRE, 1, 13'h0400);
    chk("R3 precharge all", 64'(bank_active), 64'(4'b0000));
    cyc(1, 0, C_MRS, 2, 13'h0432);
    chk("R4 mrs", 64'({mr_valid, mr_sel, mr_op}), 64'({1'b1, 2'd2, 13'h0432}));
    cyc(1, 0, C_RD, 3, 13'h0000);
    chk("R5 read idle", 64'(err_flags), 64'(4'b0001));
    cyc(1, 0, C_ACT, 3, 13'h0010);
    cyc(1, 0, C_ACT, 3, 13'h0020);
    chk("R5 reopen", 64'(err_flags), 64'(4'b0011));
    chk("R5 row kept", 64'(open_rows[39 +: 13]), 64'(13'h0010));
    cyc(1, 0, C_REF, 0, 13'h0000);
    chk("R6 refresh open", 64'(err_flags), 64'(4'b0111));
    cyc(1, 0, C_RD, 3, 13'h0400);
    cyc(1, 1, C_NOP, 0, 0); cyc(1, 1, C_NOP, 0, 0); cyc(1, 1, C_NOP, 0, 0);
    chk("R7 still open", 64'(bank_active[3]), 64'(1));
    cyc(1, 1, C_NOP, 0, 0);
    chk("R7 auto close", 64'(bank_active[3]), 64'(0));
    cyc(1, 0, C_ACT, 0, 13'h0011);
    cyc(1, 0, C_RD, 0, 13'h0400);
    cyc(1, 0, C_BST, 0, 13'h0000);
    chk("R7 terminate closes", 64'(bank_active[0]), 64'(0));
    cyc(1, 0, C_ACT, 1, 13'h0033);
    cyc(1, 0, C_WR, 1, 13'h0000);
    cyc(0, 1, C_NOP, 0, 0);
    chk("R9 cke in burst", 64'(err_flags[3]), 64'(1));
    chk("R8 active pd", 64'(pwr_mode), 64'(2));
    cyc(0, 0, C_ACT, 2, 13'h0044);
    chk("R10 ignored in pd", 64'(bank_active), 64'(4'b0010));
    cyc(1, 1, C_NOP, 0, 0);
    chk("R10 wake", 64'({pwr_mode, bank_active}), 64'(0));
    cyc(0, 0, C_REF, 0, 0);
    chk("R8 self refresh", 64'(pwr_mode), 64'(3));
    cyc(1, 1, C_NOP, 0, 0);
    cyc(0, 0, C_ACT, 2, 13'h0099);
    chk("R8 precharge pd", 64'(pwr_mode), 64'(1));
    chk("R10 entry edge ignored", 64'(bank_active), 64'(0));
    cyc(1, 1, C_NOP, 0, 0);
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] cm;
      logic k;
      int r;
      if (n % 600 == 599) rst = 1'b1;
      r = int'($urandom % 16);
      cm = (r < 4) ? C_ACT : (r < 7) ? C_RD : (r < 9) ? C_WR : (r < 11) ? C_PRE :
           (r == 11) ? C_REF : (r == 12) ? C_MRS : (r == 13) ? C_BST : C_NOP;
      if (m_pwr != 0) k = ($urandom % 3) == 0;
      else k = ($urandom % 40) != 0;
      cyc(k, ($urandom % 8) == 0, cm, 2'($urandom),
          {2'($urandom), 1'(($urandom % 3) == 0), 10'($urandom)});
      rst = 1'b0;
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule